// File: doc/BRIEF.md
# Instruction Timing and Decode Controller

This block is the timing and decode core of the hardwired control unit of a small 16-bit accumulator machine. A four-bit step counter advances on every clock and is expanded into sixteen one-hot step lines. The machine uses these lines to sequence fetch, decode and execution. On the first two steps the block raises the fetch strobes. The memory word presented on `instr_word` during step T1 is latched into an internal instruction register. On step T2 the three opcode bits are expanded into eight opcode lines, and the top bit is stored as the indirect flag.

At step T3 the block raises exactly one of four path strobes. Opcode line 7 together with the indirect flag selects the path. For register-reference and input-output words the step counter then returns to T0 so that fetch restarts. For memory-reference words the counter moves on to T4 and keeps counting until the execution logic pulses `exec_done`. It also wraps to T0 if it runs past T15. The execution logic itself is not part of this block.

Top module: `ctl_timing_decode`

## Requirements
- R1: A synchronous reset leaves only T0 active after the next edge. It clears all opcode lines, the indirect flag and the operand field, and it takes priority over every other input.
- R2: Exactly one step line is active at all times. Unless a clear condition holds, the step index rises by one per clock, modulo 16.
- R3: `fetch_ar_pc` is high only in T0. `fetch_ir_mem` and `fetch_pc_inc` are high only in T1. The word on `instr_word` at the T1 edge is latched. Its low 12 bits appear on `ir_operand` from T2 until the next T1 edge.
- R4: At the T2 edge, `d_line` becomes one-hot at index `instr[14:12]` of the latched word, and `ind_bit` becomes its bit 15. Both hold their values at every other edge.
- R5: In T3 exactly one path strobe is high, and outside T3 none is. With D7=0, I=1 the strobe is `path_ind_read`. With D7=0, I=0 it is `path_direct`. With D7=1, I=0 it is `path_reg_exec`. With D7=1, I=1 it is `path_io_exec`.
- R6: After a T3 step with D7=1, the next step is T0.
- R7: After a T3 step with D7=0, the next step is T4, even when `exec_done` is high in that T3 cycle.
- R8: With D7=0, `exec_done` high in any step T4..T15 makes the next step T0.
- R9: With D7=0 and no `exec_done`, the counter walks T4..T15 and then wraps to T0.
- R10: `exec_done` has no effect in steps T0, T1 and T2, and the counter advances normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 16 | Memory word offered during fetch |
| exec_done | input | 1 | Pulse from execution logic ending a memory-reference instruction |
| t_line | output | 16 | One-hot step lines T0..T15 |
| d_line | output | 8 | Decoded opcode lines D0..D7 |
| ind_bit | output | 1 | Indirect-address flag |
| ir_operand | output | 12 | Address/operation field of the latched word |
| fetch_ar_pc | output | 1 | T0 strobe: program counter to address register |
| fetch_ir_mem | output | 1 | T1 strobe: memory word to instruction register |
| fetch_pc_inc | output | 1 | T1 strobe: increment program counter |
| path_ind_read | output | 1 | T3: read effective address from memory |
| path_direct | output | 1 | T3: direct memory-reference, no action |
| path_reg_exec | output | 1 | T3: run register-reference instruction |
| path_io_exec | output | 1 | T3: run input-output instruction |

## Verification
Two functions can compete for the counter in the same cycle: the fixed T3 path step and the completion strobe from the execution logic. A completion pulse in T3 of a memory-reference word must lose, and the counter must move to T4. A pulse in T4 or later must win and return the counter to T0. The bench drives `exec_done` in T3 directly, and also randomly in every step, on top of the fixed-seed random instruction stream. A reference model of the counter rules decides the expected next step line after each edge, so each collision is judged by the step that follows it. Reset colliding with a completion pulse is provoked the same way.

// File: rtl/ctl_timing_pkg.sv
package ctl_timing_pkg;

  typedef struct packed {
    logic ind_read;
    logic direct;
    logic reg_exec;
    logic io_exec;
  } path_sel_t;

  // Four-way path choice taken in the decode-resolution step.
  function automatic path_sel_t pick_path(input logic at_t3, input logic d7, input logic ibit);
    path_sel_t p;
    p.ind_read = at_t3 & ~d7 &  ibit;
    p.direct   = at_t3 & ~d7 & ~ibit;
    p.reg_exec = at_t3 &  d7 & ~ibit;
    p.io_exec  = at_t3 &  d7 &  ibit;
    return p;
  endfunction

  // Step counter returns to zero after a short instruction or a finished memory one.
  function automatic logic clear_request(input logic at_t3, input logic late, input logic d7,
                                         input logic done);
    return (at_t3 & d7) | (late & ~d7 & done);
  endfunction

endpackage

// File: rtl/ctl_step_counter.sv
module ctl_step_counter #(
  parameter int STEP_W = 4,
  localparam int NSTEP = 1 << STEP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sc_clr,
  input  logic             sc_inc,
  output logic [NSTEP-1:0] t_line
);
  logic [STEP_W-1:0] sc;

  always_ff @(posedge clk) begin
    if (rst || sc_clr) sc <= '0;
    else if (sc_inc)   sc <= sc + 1'b1;
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    assign t_line[g] = (sc == STEP_W'(g));
  end

  // R2: increment moves the active line up by one position (modulo NSTEP)
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (sc_inc && !sc_clr) |=> (t_line == {$past(t_line[NSTEP-2:0]), $past(t_line[NSTEP-1])}));

  // R2: one step line at a time once out of reset
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || !$past(rst) |-> $onehot(t_line));

endmodule

// File: rtl/ctl_opcode_decode.sv
module ctl_opcode_decode #(
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  localparam int NOP   = 1 << OP_W,
  localparam int OP_HI = WORD_W - 2,
  localparam int OP_LO = WORD_W - 1 - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              ld_ir,
  input  logic              ld_dec,
  output logic [NOP-1:0]    d_line,
  output logic              ind_bit,
  output logic [OP_LO-1:0]  ir_operand
);
  logic [WORD_W-1:0] ir;
  logic [NOP-1:0]    dec_line;

  always_ff @(posedge clk) begin
    if (rst)        ir <= '0;
    else if (ld_ir) ir <= instr_word;
  end

  for (genvar g = 0; g < NOP; g++) begin : g_op
    assign dec_line[g] = (ir[OP_HI:OP_LO] == OP_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_line  <= '0;
      ind_bit <= 1'b0;
    end else if (ld_dec) begin
      d_line  <= dec_line;
      ind_bit <= ir[WORD_W-1];
    end
  end

  assign ir_operand = ir[OP_LO-1:0];

  // R4: opcode lines and indirect flag change only on the decode step
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_dec |=> ($stable(d_line) && $stable(ind_bit)));

  // R4: after a decode step exactly one opcode line is raised
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    ld_dec |=> $onehot(d_line));

  // R3: the operand field follows the word latched on the load step
  a_r3_latch: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> (ir_operand == $past(instr_word[OP_LO-1:0])));

endmodule

// File: rtl/ctl_path_select.sv
module ctl_path_select
  import ctl_timing_pkg::*;
(
  input  logic t_fetch0,
  input  logic t_fetch1,
  input  logic t_path,
  input  logic t_late,
  input  logic d7,
  input  logic ibit,
  input  logic exec_done,
  output logic fetch_ar_pc,
  output logic fetch_ir_mem,
  output logic fetch_pc_inc,
  output logic path_ind_read,
  output logic path_direct,
  output logic path_reg_exec,
  output logic path_io_exec,
  output logic sc_clr,
  output logic sc_inc
);
  path_sel_t sel;

  always_comb begin
    sel           = pick_path(t_path, d7, ibit);
    path_ind_read = sel.ind_read;
    path_direct   = sel.direct;
    path_reg_exec = sel.reg_exec;
    path_io_exec  = sel.io_exec;
    fetch_ar_pc   = t_fetch0;
    fetch_ir_mem  = t_fetch1;
    fetch_pc_inc  = t_fetch1;
    sc_clr        = clear_request(t_path, t_late, d7, exec_done);
    sc_inc        = ~sc_clr;
  end

endmodule

// File: rtl/ctl_timing_decode.sv
module ctl_timing_decode #(
  parameter int STEP_W   = 4,
  parameter int WORD_W   = 16,
  parameter int OP_W     = 3,
  parameter int MEM_STEP = 4,
  localparam int NSTEP   = 1 << STEP_W,
  localparam int NOP     = 1 << OP_W,
  localparam int OPND_W  = WORD_W - 1 - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              exec_done,
  output logic [NSTEP-1:0]  t_line,
  output logic [NOP-1:0]    d_line,
  output logic              ind_bit,
  output logic [OPND_W-1:0] ir_operand,
  output logic              fetch_ar_pc,
  output logic              fetch_ir_mem,
  output logic              fetch_pc_inc,
  output logic              path_ind_read,
  output logic              path_direct,
  output logic              path_reg_exec,
  output logic              path_io_exec
);
  logic sc_clr, sc_inc;
  logic t_late;

  assign t_late = |t_line[NSTEP-1:MEM_STEP];

  ctl_step_counter #(.STEP_W(STEP_W)) u_sc (
    .clk    (clk),
    .rst    (rst),
    .sc_clr (sc_clr),
    .sc_inc (sc_inc),
    .t_line (t_line)
  );

  ctl_opcode_decode #(.WORD_W(WORD_W), .OP_W(OP_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .instr_word (instr_word),
    .ld_ir      (t_line[1]),
    .ld_dec     (t_line[2]),
    .d_line     (d_line),
    .ind_bit    (ind_bit),
    .ir_operand (ir_operand)
  );

  ctl_path_select u_path (
    .t_fetch0      (t_line[0]),
    .t_fetch1      (t_line[1]),
    .t_path        (t_line[3]),
    .t_late        (t_late),
    .d7            (d_line[NOP-1]),
    .ibit          (ind_bit),
    .exec_done     (exec_done),
    .fetch_ar_pc   (fetch_ar_pc),
    .fetch_ir_mem  (fetch_ir_mem),
    .fetch_pc_inc  (fetch_pc_inc),
    .path_ind_read (path_ind_read),
    .path_direct   (path_direct),
    .path_reg_exec (path_reg_exec),
    .path_io_exec  (path_io_exec),
    .sc_clr        (sc_clr),
    .sc_inc        (sc_inc)
  );

  // R1: reset returns the step lines to T0
  a_r1_reset: assert property (@(posedge clk) rst |=> (t_line == NSTEP'(1)));

  // R3: address fetch strobe is followed by the word-load strobe
  a_r3_fetch_order: assert property (@(posedge clk) disable iff (rst)
    fetch_ar_pc |=> fetch_ir_mem);

  // R5: one path strobe in T3, none elsewhere
  a_r5_one_path: assert property (@(posedge clk) disable iff (rst)
    t_line[3] |-> $onehot({path_ind_read, path_direct, path_reg_exec, path_io_exec}));
  a_r5_no_path: assert property (@(posedge clk) disable iff (rst)
    !t_line[3] |-> ({path_ind_read, path_direct, path_reg_exec, path_io_exec} == 4'b0));

  // R6: short instructions restart fetch
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (path_reg_exec || path_io_exec) |=> t_line[0]);

  // R7: memory-reference words continue at T4
  a_r7_continue: assert property (@(posedge clk) disable iff (rst)
    (path_ind_read || path_direct) |=> t_line[MEM_STEP]);

  // R8: completion pulse in a late step ends a memory-reference instruction
  a_r8_done: assert property (@(posedge clk) disable iff (rst)
    (exec_done && t_late && !d_line[NOP-1]) |=> t_line[0]);

  // R10: completion pulse during fetch and decode does not disturb the sequence
  a_r10_fetch_t0: assert property (@(posedge clk) disable iff (rst)
    t_line[0] |=> t_line[1]);
  a_r10_fetch_t1: assert property (@(posedge clk) disable iff (rst)
    t_line[1] |=> t_line[2]);

endmodule

// File: tb/tb_ctl_timing_decode.sv
module tb_ctl_timing_decode;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr_word;
  logic        exec_done;
  logic [15:0] t_line;
  logic [7:0]  d_line;
  logic        ind_bit;
  logic [11:0] ir_operand;
  logic        fetch_ar_pc, fetch_ir_mem, fetch_pc_inc;
  logic        path_ind_read, path_direct, path_reg_exec, path_io_exec;

  int checks = 0;
  int failures = 0;

  // reference model state
  int          m_sc;
  logic [15:0] m_ir;
  logic [7:0]  m_d;
  logic        m_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_timing_decode dut (
    .clk(clk), .rst(rst), .instr_word(instr_word), .exec_done(exec_done),
    .t_line(t_line), .d_line(d_line), .ind_bit(ind_bit), .ir_operand(ir_operand),
    .fetch_ar_pc(fetch_ar_pc), .fetch_ir_mem(fetch_ir_mem), .fetch_pc_inc(fetch_pc_inc),
    .path_ind_read(path_ind_read), .path_direct(path_direct),
    .path_reg_exec(path_reg_exec), .path_io_exec(path_io_exec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int next_step(input int sc, input logic d7, input logic done);
    if (sc == 3 && d7) return 0;
    if (sc >= 4 && !d7 && done) return 0;
    return (sc + 1) % 16;
  endfunction

  function automatic logic [3:0] exp_path(input int sc, input logic d7, input logic i);
    if (sc != 3) return 4'b0000;
    return {~d7 & i, ~d7 & ~i, d7 & ~i, d7 & i};
  endfunction

  task automatic model_update(input logic r, input logic [15:0] w, input logic done);
    if (r) begin
      m_sc = 0; m_ir = '0; m_d = '0; m_i = 1'b0;
    end else begin
      int nsc;
      nsc = next_step(m_sc, m_d[7], done);
      if (m_sc == 1) m_ir = w;
      if (m_sc == 2) begin
        m_d = 8'(1) << m_ir[14:12];
        m_i = m_ir[15];
      end
      m_sc = nsc;
    end
  endtask

  task automatic compare_all();
    chk("R2 t_line", 32'(t_line), 32'(16'(1) << m_sc));
    chk("R4 d_line", 32'(d_line), 32'(m_d));
    chk("R4 ind_bit", 32'(ind_bit), 32'(m_i));
    chk("R3 ir_operand", 32'(ir_operand), 32'(m_ir[11:0]));
    chk("R3 fetch strobes", 32'({fetch_ar_pc, fetch_ir_mem, fetch_pc_inc}),
        32'({m_sc == 0, m_sc == 1, m_sc == 1}));
    chk("R5 path strobes", 32'({path_ind_read, path_direct, path_reg_exec, path_io_exec}),
        32'(exp_path(m_sc, m_d[7], m_i)));
  endtask

  task automatic step(input logic r, input logic [15:0] w, input logic done);
    @(negedge clk);
    rst = r; instr_word = w; exec_done = done;
    @(posedge clk);
    #1;
    model_update(r, w, done);
    compare_all();
  endtask

  // fetch a word: T0 -> T1 -> T2 -> T3, word offered through T1
  task automatic fetch(input logic [15:0] w, input logic done);
    step(1'b0, 16'hDEAD, done);
    step(1'b0, w, done);
    step(1'b0, 16'h0000, done);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_C0DE));
    rst = 1'b1; instr_word = '0; exec_done = 1'b0;
    m_sc = 0; m_ir = '0; m_d = '0; m_i = 1'b0;
    // R1: reset with a colliding completion pulse
    step(1'b1, 16'hFFFF, 1'b1);
    step(1'b1, 16'h0000, 1'b0);
    chk("R1 t_line after reset", 32'(t_line), 32'h1);
    chk("R1 d_line after reset", 32'(d_line), 32'h0);

    // R6: register-reference word 0x7xxx
    fetch(16'h7040, 1'b0);
    chk("R5 reg path in T3", 32'(path_reg_exec), 32'h1);
    step(1'b0, 16'h0, 1'b0);
    chk("R6 reg restart T0", 32'(t_line), 32'h1);

    // R6: input-output word 0xFxxx
    fetch(16'hF123, 1'b0);
    chk("R5 io path in T3", 32'(path_io_exec), 32'h1);
    step(1'b0, 16'h0, 1'b1);
    chk("R6 io restart T0", 32'(t_line), 32'h1);

    // R10: completion pulses during fetch/decode have no effect
    step(1'b0, 16'h0, 1'b1);
    chk("R10 T0 pulse ignored", 32'(t_line), 32'h2);
    step(1'b0, 16'h8ABC, 1'b1);
    chk("R10 T1 pulse ignored", 32'(t_line), 32'h4);
    step(1'b0, 16'h0, 1'b1);
    chk("R10 T2 pulse ignored", 32'(t_line), 32'h8);
    chk("R5 indirect path", 32'(path_ind_read), 32'h1);
    chk("R4 indirect flag", 32'(ind_bit), 32'h1);
    // R7: pulse in T3 of memory-reference word loses
    step(1'b0, 16'h0, 1'b1);
    chk("R7 T3 pulse ignored, at T4", 32'(t_line), 32'h10);
    step(1'b0, 16'h0, 1'b0);
    step(1'b0, 16'h0, 1'b0);
    chk("R9 still counting T6", 32'(t_line), 32'h40);
    step(1'b0, 16'h0, 1'b1);
    chk("R8 pulse at T6 clears", 32'(t_line), 32'h1);

    // R9: direct memory-reference, no completion, wraps after T15
    fetch(16'h2345, 1'b0);
    chk("R5 direct path", 32'(path_direct), 32'h1);
    for (int k = 0; k < 12; k++) step(1'b0, 16'h0, 1'b0);
    chk("R9 reached T15", 32'(t_line), 32'h8000);
    step(1'b0, 16'h0, 1'b0);
    chk("R9 wrapped to T0", 32'(t_line), 32'h1);
    chk("R4 opcode held across wrap", 32'(d_line), 32'h04);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic r, dn;
      logic [15:0] w;
      r  = ($urandom_range(0, 99) == 0);
      dn = ($urandom_range(0, 5) == 0);
      w  = 16'($urandom);
      step(r, w, dn);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule